// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a simple internal request port to an external parallel bus. The request port carries an address, write data, a read/write flag and a valid signal, and it returns a ready pulse and read data. On the external side, the low address byte and the data byte share one byte lane. The upper address bits have their own port. An address latch enable (ALE) output marks the address phase, and active-low read and write strobes mark the data phase.

Each request is routed by address. Addresses below a fixed internal limit go to on-chip memory. Addresses at or above it go to the external bus when the interface is enabled, and are unmapped when it is disabled. External space is split into a lower and an upper sector at a programmable boundary, and each sector has its own wait count of 0 to 3 clocks. With the interface enabled, internal accesses still run the address phase on the bus, but they never pulse a strobe. The number of upper address pins taken over is programmable. An optional keeper holds the last lane value while the lane is released.

Top module: `xbus_ctrl`

## Requirements
- R1: An address below `INT_SIZE` (default 0x1100) is internal. An address at or above it is external.
- R2: With the interface enabled, every access begins with `ale` high for exactly one clock. In that clock `ad_oe` is 1 and `ad_out` carries address bits [7:0]. After that, `ale` stays low until ready, and `ale` is never high while a strobe is low.
- R3: An external access holds its strobe low for 1+N consecutive clocks. N is the 2-bit wait code of the selected sector, and code k means k wait clocks. With the interface enabled, ready follows N+3 clocks after the request is raised.
- R4: An external address below `cfg_split` uses `cfg_ws_lo`. Any other external address uses `cfg_ws_hi`.
- R5: While `wr_n` is low, `ad_oe` is 1 and `ad_out` equals the write data. While `rd_n` is low, `ad_oe` is 0. For an external read, `req_rdata` is the `ad_in` value sampled on the last strobe clock.
- R6: An enabled internal access pulses `ale` once and never lowers `rd_n` or `wr_n`. It uses zero wait clocks, so ready comes 3 clocks after the request. Its read data is taken from `int_rdata`.
- R7: With the interface enabled, bit i of `hi_oe` is 1 exactly when i < `cfg_hi_bits`. During the address phase, `hi_out` carries address bits [15:8] masked by `hi_oe`.
- R8: With the interface disabled, the bus stays idle: `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=0, `hi_oe`=0 and `bus_own`=0. A request is acknowledged 2 clocks after it is raised. Read data is `int_rdata` for an internal address and 0 for an unmapped address.
- R9: When `cfg_en` and `cfg_keep` are both 1 and the lane is not driven, `ad_keep`=1. In that case `ad_out` shows the last lane value, which is either the last driven byte or the last external read byte. When `cfg_keep`=0, `ad_keep`=0 and an undriven `ad_out` reads 0.
- R10: A held request produces exactly one transaction: at most one `ale` pulse, and `req_ready` high for a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Interface enable; takes over the bus pins |
| cfg_keep | input | 1 | Lane keeper enable |
| cfg_split | input | 16 | Boundary between the lower and upper external sectors |
| cfg_ws_lo | input | 2 | Wait code for the lower sector |
| cfg_ws_hi | input | 2 | Wait code for the upper sector |
| cfg_hi_bits | input | 4 | Number of upper address pins driven (0..8) |
| req_valid | input | 1 | Request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 8 | Read data, valid with ready |
| int_rdata | input | 8 | Read data from on-chip memory |
| ad_in | input | 8 | Value sensed on the shared lane |
| ad_out | output | 8 | Value driven or kept on the shared lane |
| ad_oe | output | 1 | Lane output enable |
| ad_keep | output | 1 | Keeper active on the lane |
| hi_out | output | 8 | Upper address bits |
| hi_oe | output | 8 | Per-pin takeover of the upper address port |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_own | output | 1 | Takeover of the lane and control pins |

## Verification
Two cases are hard to reach from the ports. The first is the sector boundary, where the split address and the address one below it must select different wait codes. The bench sets the two sector codes to opposite extremes and issues reads at both neighbouring addresses. The second is the keeper value left after a transfer, which is only visible once the block returns to idle. The bench therefore samples `ad_out` in the idle clock after each write and each external read, and again after turning the keeper off.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ADDR  = 3'd1,
    S_STRB  = 3'd2,
    S_LOCAL = 3'd3,
    S_DONE  = 3'd4
  } xstate_t;

  typedef enum logic [1:0] {
    RT_INT  = 2'd0,
    RT_EXT  = 2'd1,
    RT_NONE = 2'd2
  } route_t;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WS_W     = 2,
  parameter int INT_SIZE = 'h1100
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] split,
  input  logic [WS_W-1:0]   ws_lo,
  input  logic [WS_W-1:0]   ws_hi,
  output route_t            route,
  output logic [WS_W-1:0]   ws
);
  localparam logic [ADDR_W-1:0] INT_LIM = ADDR_W'(INT_SIZE);

  function automatic route_t route_of(input logic e, input logic [ADDR_W-1:0] a);
    if (a < INT_LIM) return RT_INT;
    return e ? RT_EXT : RT_NONE;
  endfunction

  function automatic logic [WS_W-1:0] ws_of(input route_t r, input logic [ADDR_W-1:0] a,
                                            input logic [ADDR_W-1:0] s,
                                            input logic [WS_W-1:0] lo,
                                            input logic [WS_W-1:0] hi);
    if (r != RT_EXT) return '0;
    return (a < s) ? lo : hi;
  endfunction

  always_comb begin
    route = route_of(en, addr);
    ws    = ws_of(route, addr, split, ws_lo, ws_hi);
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            en,
  input  logic [WS_W-1:0] ws_hold,
  output xstate_t         st,
  output logic            accept,
  output logic            strb_last
);
  logic [WS_W-1:0] cnt;

  assign accept    = (st == S_IDLE) && req_valid;
  assign strb_last = (st == S_STRB) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE:  if (req_valid) st <= en ? S_ADDR : S_LOCAL;
        S_ADDR:  begin cnt <= ws_hold; st <= S_STRB; end
        S_STRB:  if (cnt == '0) st <= S_DONE; else cnt <= cnt - 1'b1;
        S_LOCAL: st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: the wait counter never exceeds the captured wait code
  assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRB) |-> (cnt <= ws_hold));
  // R10: completion state lasts a single clock
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |=> (st == S_IDLE));
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         keep_on,
  input  logic         drive,
  input  logic [W-1:0] drv_val,
  input  logic         samp,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] ad_out,
  output logic         ad_oe,
  output logic         ad_keep
);
  logic [W-1:0] keep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= '0;
    else if (en) begin
      if (drive)     keep_q <= drv_val;
      else if (samp) keep_q <= ad_in;
    end
  end

  assign ad_oe   = en && drive;
  assign ad_keep = en && keep_on && !drive;
  assign ad_out  = ad_oe ? drv_val : (ad_keep ? keep_q : '0);

  // R9: a kept lane holds still unless a read byte is captured
  assert_keep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_keep && $past(ad_keep) && !$past(samp)) |-> (ad_out == $past(ad_out)));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int LANE_W   = 8,
  parameter int HI_W     = 8,
  parameter int WS_W     = 2,
  parameter int INT_SIZE = 'h1100,
  localparam int ADDR_W  = LANE_W + HI_W,
  localparam int HB_W    = $clog2(HI_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_keep,
  input  logic [ADDR_W-1:0] cfg_split,
  input  logic [WS_W-1:0]   cfg_ws_lo,
  input  logic [WS_W-1:0]   cfg_ws_hi,
  input  logic [HB_W-1:0]   cfg_hi_bits,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [LANE_W-1:0] req_rdata,
  input  logic [LANE_W-1:0] int_rdata,
  input  logic [LANE_W-1:0] ad_in,
  output logic [LANE_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ad_keep,
  output logic [HI_W-1:0]   hi_out,
  output logic [HI_W-1:0]   hi_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_own
);
  function automatic logic [HI_W-1:0] hi_mask(input logic [HB_W-1:0] n);
    logic [HI_W-1:0] m;
    for (int i = 0; i < HI_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  route_t              dec_route, route_q;
  logic [WS_W-1:0]     dec_ws, ws_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANE_W-1:0]   wd_q, rdata_q;
  logic                we_q;
  xstate_t             st;
  logic                accept, strb_last;
  logic                strobe_on, lane_drive, samp_ext;
  logic [LANE_W-1:0]   lane_val;

  xbus_decode #(.ADDR_W(ADDR_W), .WS_W(WS_W), .INT_SIZE(INT_SIZE)) u_dec (
    .en(cfg_en), .addr(req_addr), .split(cfg_split),
    .ws_lo(cfg_ws_lo), .ws_hi(cfg_ws_hi), .route(dec_route), .ws(dec_ws)
  );

  xbus_seq #(.WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .en(cfg_en),
    .ws_hold(ws_q), .st(st), .accept(accept), .strb_last(strb_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= RT_INT;
      ws_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      route_q <= dec_route;
      ws_q    <= dec_ws;
      addr_q  <= req_addr;
      wd_q    <= req_wdata;
      we_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if ((strb_last || st == S_LOCAL) && !we_q) begin
      unique case (route_q)
        RT_EXT:  rdata_q <= ad_in;
        RT_INT:  rdata_q <= int_rdata;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign strobe_on  = cfg_en && (st == S_STRB) && (route_q == RT_EXT);
  assign rd_n       = !(strobe_on && !we_q);
  assign wr_n       = !(strobe_on && we_q);
  assign ale        = cfg_en && (st == S_ADDR);
  assign lane_drive = (st == S_ADDR) || ((st == S_STRB) && we_q);
  assign lane_val   = (st == S_ADDR) ? addr_q[LANE_W-1:0] : wd_q;
  assign samp_ext   = strb_last && (route_q == RT_EXT) && !we_q;
  assign req_ready  = (st == S_DONE);
  assign req_rdata  = rdata_q;
  assign bus_own    = cfg_en;
  assign hi_oe      = cfg_en ? hi_mask(cfg_hi_bits) : '0;
  assign hi_out     = addr_q[ADDR_W-1 -: HI_W] & hi_oe;

  xbus_lane #(.W(LANE_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .keep_on(cfg_keep),
    .drive(lane_drive), .drv_val(lane_val), .samp(samp_ext), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_keep(ad_keep)
  );

  // R2: address phase is one clock and never overlaps a strobe
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe));
  // R5: lane direction follows the active strobe
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  assert_write_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && ad_out == wd_q));
  // R6: internal accesses leave both strobes idle
  assert_int_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == RT_INT && st != S_IDLE) |-> (rd_n && wr_n));
  // R8: disabled interface keeps the bus idle
  assert_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (!ale && rd_n && wr_n && !ad_oe && hi_oe == '0));
  // R10: ready is a single-clock pulse
  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  assert_strobes_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || wr_n));
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_keep = 1'b0;
  logic [15:0] cfg_split = 16'h8000;
  logic [1:0]  cfg_ws_lo = 2'd0, cfg_ws_hi = 2'd0;
  logic [3:0]  cfg_hi_bits = 4'd8;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, int_rdata = '0, ad_in = '0;
  logic        req_ready, ad_oe, ad_keep, ale, rd_n, wr_n, bus_own;
  logic [7:0]  req_rdata, ad_out, hi_out, hi_oe;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_keep(cfg_keep),
    .cfg_split(cfg_split), .cfg_ws_lo(cfg_ws_lo), .cfg_ws_hi(cfg_ws_hi),
    .cfg_hi_bits(cfg_hi_bits), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .int_rdata(int_rdata), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_keep(ad_keep), .hi_out(hi_out),
    .hi_oe(hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bus_own(bus_own)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one request, tallying bus activity on each falling edge until ready
  task automatic xfer(input logic we, input logic [15:0] a, input logic [7:0] wd,
                      output logic [7:0] rd, output int cyc, output int ale_c,
                      output int rd_c, output int wr_c, output int bad,
                      output logic [7:0] hoe, output logic [7:0] hout);
    cyc = 0; ale_c = 0; rd_c = 0; wr_c = 0; bad = 0; hoe = '0; hout = '0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc++;
      if (ale) begin
        ale_c++; hoe = hi_oe; hout = hi_out;
        if (!(ad_oe && ad_out == a[7:0])) bad++;
      end
      if (!rd_n) begin rd_c++; if (ad_oe) bad++; end
      if (!wr_n) begin wr_c++; if (!(ad_oe && ad_out == wd)) bad++; end
      if (req_ready) begin rd = req_rdata; break; end
    end
    req_valid = 1'b0;
    @(negedge clk);
    if (req_ready || ale) bad++;
  endtask

  task automatic t_reset();
    chk("R8", "ale at reset", ale, 0);
    chk("R8", "rd_n at reset", rd_n, 1);
    chk("R8", "wr_n at reset", wr_n, 1);
    chk("R8", "ad_oe at reset", ad_oe, 0);
    chk("R8", "hi_oe at reset", hi_oe, 0);
    chk("R8", "bus_own at reset", bus_own, 0);
    chk("R10", "ready at reset", req_ready, 0);
  endtask

  task automatic t_wait_codes();
    logic [7:0] rd, hoe, hout; int cyc, a, r, w, bad;
    cfg_en = 1'b1; cfg_split = 16'h8000;
    for (int k = 0; k < 4; k++) begin
      cfg_ws_lo = 2'(k); ad_in = 8'h30 + 8'(k);
      xfer(1'b0, 16'h2000 + 16'(k), 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
      chk("R3", "read strobe length", r, k + 1);
      chk("R3", "read latency", cyc, k + 3);
      chk("R5", "read data", rd, 'h30 + k);
      chk("R2", "ale pulses", a, 1);
      chk("R5", "lane protocol errors", bad, 0);
    end
  endtask

  task automatic t_sector();
    logic [7:0] rd, hoe, hout; int cyc, a, r, w, bad;
    cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd3; cfg_split = 16'h8000;
    xfer(1'b0, 16'h7FFF, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R4", "below split strobe", r, 1);
    xfer(1'b0, 16'h8000, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R4", "at split strobe", r, 4);
    cfg_ws_lo = 2'd2; cfg_ws_hi = 2'd1; cfg_split = 16'h4000;
    xfer(1'b1, 16'h3FFF, 8'h11, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R4", "write lower sector strobe", w, 3);
    xfer(1'b1, 16'hF000, 8'h22, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R4", "write upper sector strobe", w, 2);
  endtask

  task automatic t_write_keep();
    logic [7:0] rd, hoe, hout; int cyc, a, r, w, bad;
    cfg_keep = 1'b1; cfg_ws_hi = 2'd1;
    xfer(1'b1, 16'hA55A, 8'hC3, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R5", "write strobe length", w, 2);
    chk("R5", "write lane errors", bad, 0);
    chk("R5", "no read strobe on write", r, 0);
    chk("R9", "keeper active idle", ad_keep, 1);
    chk("R9", "keeper holds write byte", ad_out, 'hC3);
    ad_in = 8'h3C;
    xfer(1'b0, 16'hB001, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R9", "keeper holds read byte", ad_out, 'h3C);
    cfg_keep = 1'b0;
    @(negedge clk);
    chk("R9", "keeper off flag", ad_keep, 0);
    chk("R9", "keeper off lane", ad_out, 0);
  endtask

  task automatic t_internal();
    logic [7:0] rd, hoe, hout; int cyc, a, r, w, bad;
    cfg_ws_lo = 2'd3; cfg_ws_hi = 2'd3; int_rdata = 8'h9D; ad_in = 8'h44;
    xfer(1'b0, 16'h10FF, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R1", "0x10FF internal no strobe", r, 0);
    chk("R6", "internal ale pulse", a, 1);
    chk("R6", "internal latency", cyc, 3);
    chk("R6", "internal read data", rd, 'h9D);
    xfer(1'b1, 16'h0040, 8'h77, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R6", "internal write no strobe", w, 0);
    chk("R10", "internal write ale once", a, 1);
    xfer(1'b0, 16'h1100, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R1", "0x1100 external strobe", r, 4);
    chk("R1", "0x1100 external data", rd, 'h44);
  endtask

  task automatic t_hibits();
    logic [7:0] rd, hoe, hout; int cyc, a, r, w, bad;
    cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd0;
    cfg_hi_bits = 4'd3;
    xfer(1'b0, 16'hED12, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R7", "hi_oe 3 bits", hoe, 'h07);
    chk("R7", "hi_out 3 bits", hout, 'h05);
    cfg_hi_bits = 4'd0;
    xfer(1'b0, 16'hED12, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R7", "hi_oe 0 bits", hoe, 0);
    cfg_hi_bits = 4'd8;
    xfer(1'b0, 16'hED12, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R7", "hi_oe 8 bits", hoe, 'hFF);
    chk("R7", "hi_out 8 bits", hout, 'hED);
  endtask

  task automatic t_disabled();
    logic [7:0] rd, hoe, hout; int cyc, a, r, w, bad;
    cfg_en = 1'b0; int_rdata = 8'h5E; ad_in = 8'hAA;
    @(negedge clk);
    chk("R8", "bus_own off", bus_own, 0);
    chk("R8", "hi_oe off", hi_oe, 0);
    xfer(1'b0, 16'h0200, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R8", "off internal latency", cyc, 2);
    chk("R8", "off internal data", rd, 'h5E);
    chk("R8", "off no ale", a, 0);
    xfer(1'b0, 16'h9000, 8'h00, rd, cyc, a, r, w, bad, hoe, hout);
    chk("R8", "off unmapped data", rd, 0);
    chk("R8", "off unmapped strobes", r + w, 0);
    chk("R8", "off lane idle", ad_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_wait_codes();
    t_sector();
    t_write_keep();
    t_internal();
    t_hibits();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule